// File: doc/BRIEF.md
# Scrambled Clock Pattern Generator

This block produces a timing signal whose level may change only on the rising edges of a fixed-rate master clock. It is not a square wave. On each enabled cycle the output carries the next bit of a fixed, balanced, 256-bit pseudorandom pattern, much like NRZ serial data. The pattern repeats without a gap. Because the edges stay on a fixed time grid while their polarity is scrambled, the emitted energy spreads over many spectral lines and the edge timing gains no jitter.

A transition-counting divider comes with the generator. It watches the scrambled stream and emits a one-cycle reference pulse on every Nth level change, where N is the number of level changes in one pattern period counted around the wrap. With the generator running, this gives exactly one pulse per period, which a receiving PLL can use as an acquisition aid. A start marker flags the cycle in which the output carries pattern bit 0.

Top module: `scr_clk_gen`

## Requirements
- R1: After each enabled rising edge, `sclk_o` carries `PATTERN[k]`, where k is 0 for the first enabled edge after reset and rises by one per enabled edge, wrapping from 255 back to 0 with no bit dropped or inserted.
- R2: The default pattern is built from a 7-bit shift register s, seeded to 7'h7F. At step j (j = 0..127) a bit b = s[6] XOR s[5] is formed and s becomes {s[5:0], b}. Pattern bit 2j is b and bit 2j+1 is NOT b, and bit 0 is the vector's LSB.
- R3: Every 256-bit period of the output holds exactly 128 ones.
- R4: Every period contains at least 100 level changes, the wrap from the last bit to the first included, and no run of equal bits is longer than 6.
- R5: After every reset the output repeats the same bit sequence.
- R6: `start_o` is high exactly in the cycles where `sclk_o` carries pattern bit 0.
- R7: While `en` is low, `sclk_o`, `start_o` and the pattern position hold, and no level change is counted.
- R8: The divider compares the stream with its previous value, which reset sets to 0. `ref_o` goes high for one cycle, one cycle after the stream makes its Nth, 2Nth, 3Nth… level change since reset.
- R9: With `en` held high, consecutive `ref_o` pulses after the first period are exactly 256 cycles apart.
- R10: While `rst` is high and in the cycle after it falls, `sclk_o`, `start_o` and `ref_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the pattern on this edge |
| sclk_o | output | 1 | Scrambled clock bit |
| start_o | output | 1 | Marks the cycle carrying pattern bit 0 |
| ref_o | output | 1 | One-cycle reference pulse per N level changes |

## Verification
The stream is first driven with `en` held high for four periods. This shows that the bit order and wrap are right, that each period is balanced and dense in transitions, and that the reference pulses fall 256 cycles apart. A second run gates `en` with two interleaved cyclic patterns, which separates stalled cycles from advancing ones: a design that advances or counts while stalled shifts the stream and the pulse phase away from the model. A reset in the middle of a run, followed by a replay, checks that the sequence is repeatable. A long stall at the end confirms that every output holds.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int PAT_BITS = 256;
    localparam int IDX_W    = $clog2(PAT_BITS);
    localparam int CNT_W    = IDX_W + 1;

    typedef logic [PAT_BITS-1:0] pat_t;
    typedef logic [IDX_W-1:0]    idx_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        logic level;
        logic first;
    } ser_t;

    function automatic pat_t build_pattern();
        logic [6:0] s;
        logic       b;
        pat_t       p;
        s = 7'h7F;
        p = '0;
        for (int j = 0; j < PAT_BITS / 2; j++) begin
            b          = s[6] ^ s[5];
            s          = {s[5:0], b};
            p[2*j]     = b;
            p[2*j + 1] = ~b;
        end
        return p;
    endfunction

    function automatic int count_ones(pat_t p);
        int n;
        n = 0;
        for (int i = 0; i < PAT_BITS; i++) n += int'(p[i]);
        return n;
    endfunction

    function automatic int count_toggles(pat_t p);
        int n;
        n = 0;
        for (int i = 0; i < PAT_BITS; i++)
            if (p[i] != p[(i + 1) % PAT_BITS]) n++;
        return n;
    endfunction

    function automatic int longest_run(pat_t p);
        int run;
        int best;
        run  = 1;
        best = 1;
        for (int i = 1; i < 2 * PAT_BITS; i++) begin
            if (p[i % PAT_BITS] == p[(i - 1) % PAT_BITS]) run++;
            else run = 1;
            if (run > PAT_BITS) run = PAT_BITS;
            if (run > best) best = run;
        end
        return best;
    endfunction

    localparam pat_t DEF_PATTERN = build_pattern();

endpackage

// File: rtl/scr_pattern_seq.sv
module scr_pattern_seq
    import scr_pkg::*;
#(
    parameter pat_t PATTERN = DEF_PATTERN
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output ser_t q
);
    localparam idx_t LAST = idx_t'(PAT_BITS - 1);

    idx_t pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            q   <= '0;
        end else if (en) begin
            q.level <= PATTERN[pos];
            q.first <= (pos == '0);
            pos     <= (pos == LAST) ? '0 : pos + idx_t'(1);
        end
    end
endmodule

// File: rtl/scr_edge_det.sv
module scr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic toggle
);
    logic last;

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= din;
    end

    assign toggle = (din != last);
endmodule

// File: rtl/scr_ref_div.sv
module scr_ref_div
    import scr_pkg::*;
#(
    parameter int EDGES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    output logic pulse
);
    localparam cnt_t TOP = cnt_t'(EDGES - 1);

    cnt_t seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= toggle && (seen == TOP);
            if (toggle) seen <= (seen == TOP) ? '0 : seen + cnt_t'(1);
        end
    end
endmodule

// File: rtl/scr_clk_gen.sv
module scr_clk_gen
    import scr_pkg::*;
#(
    parameter pat_t PATTERN = DEF_PATTERN
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk_o,
    output logic start_o,
    output logic ref_o
);
    localparam int ONES    = count_ones(PATTERN);
    localparam int EDGES   = count_toggles(PATTERN);
    localparam int MAX_RUN = longest_run(PATTERN);

    generate
        if (ONES != PAT_BITS / 2) begin : g_unbalanced
            $error("pattern is not balanced");
        end
        if (EDGES < 100) begin : g_sparse
            $error("pattern has too few level changes");
        end
        if (MAX_RUN > 6) begin : g_long_run
            $error("pattern has a run longer than 6");
        end
    endgenerate

    ser_t ser;
    logic toggle;

    scr_pattern_seq #(.PATTERN(PATTERN)) u_seq (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .q   (ser)
    );

    scr_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .din    (ser.level),
        .toggle (toggle)
    );

    scr_ref_div #(.EDGES(EDGES)) u_div (
        .clk    (clk),
        .rst    (rst),
        .toggle (toggle),
        .pulse  (ref_o)
    );

    assign sclk_o  = ser.level;
    assign start_o = ser.first;
endmodule

// File: rtl/scr_clk_gen_chk.sv
module scr_clk_gen_chk
    import scr_pkg::*;
#(
    parameter pat_t PATTERN = DEF_PATTERN
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sclk_o,
    input logic start_o,
    input logic ref_o
);
    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sclk_o) && $stable(start_o)));

    // R6
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (sclk_o == PATTERN[0]));

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        (start_o && en) |=> !start_o);

    // R8
    ref_single_chk: assert property (@(posedge clk) disable iff (rst)
        ref_o |=> !ref_o);

    // R8
    ref_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_o) |-> ($past(sclk_o) != $past(sclk_o, 2)));
endmodule

bind scr_clk_gen scr_clk_gen_chk #(.PATTERN(PATTERN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .sclk_o  (sclk_o),
    .start_o (start_o),
    .ref_o   (ref_o)
);

// File: tb/tb_scr_clk_gen.sv
`timescale 1ns/1ps
module tb_scr_clk_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sclk_o, start_o, ref_o;

    always #4 clk = ~clk;

    scr_clk_gen dut (
        .clk(clk), .rst(rst), .en(en),
        .sclk_o(sclk_o), .start_o(start_o), .ref_o(ref_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit pat [256];
    int n_edges;

    // model state
    int k;
    bit m_s, m_m, m_r, m_prev;
    int m_cnt;

    // observation state
    int  cyc = 0;
    bit  prev_s, prev_m;
    bit  last_en;
    bit  stats_on;
    bit  win_open;
    int  ones, trans, run, maxrun;
    int  last_ref;
    int  spacing_checks;
    bit  first_run [256];
    int  cap_idx;
    bit  capture, compare;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic build_model_pattern();
        bit [6:0] s;
        bit b;
        s = 7'h7F;
        for (int j = 0; j < 128; j++) begin
            b = s[6] ^ s[5];
            s = {s[5:0], b};
            pat[2*j]   = b;
            pat[2*j+1] = ~b;
        end
        n_edges = 0;
        for (int i = 0; i < 256; i++)
            if (pat[i] != pat[(i + 1) % 256]) n_edges++;
    endtask

    task automatic model_step();
        bit tog;
        if (rst) begin
            k = 0; m_s = 0; m_m = 0; m_r = 0; m_prev = 0; m_cnt = 0;
        end else begin
            tog  = (m_s != m_prev);
            m_r  = tog && (m_cnt == n_edges - 1);
            if (tog) m_cnt = (m_cnt == n_edges - 1) ? 0 : m_cnt + 1;
            m_prev = m_s;
            if (en) begin
                m_s = pat[k];
                m_m = (k == 0);
                k   = (k + 1) % 256;
            end
        end
    endtask

    task automatic tick(input bit r, input bit e);
        rst = r;
        en  = e;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        check(sclk_o == m_s, "R1", sclk_o, m_s);
        check(start_o == m_m, "R6", start_o, m_m);
        check(ref_o == m_r, "R8", ref_o, m_r);
        if (r || last_en == 1'b0 && rst == 1'b0 && cyc == 1) begin
            check(sclk_o == 0 && start_o == 0 && ref_o == 0, "R10",
                  {sclk_o, start_o, ref_o}, 0);
        end
        if (!r && !e) begin
            check(sclk_o == prev_s, "R7", sclk_o, prev_s);
            check(start_o == prev_m, "R7", start_o, prev_m);
        end
        if (stats_on) begin
            if (sclk_o != prev_s) begin trans++; run = 1; end
            else run++;
            if (start_o) begin
                if (win_open) begin
                    check(ones == 128, "R3", ones, 128);
                    check(trans >= 100, "R4", trans, 100);
                    check(maxrun <= 6, "R4", maxrun, 6);
                end
                ones = 0; trans = 0; maxrun = 0; win_open = 1;
            end
            ones += int'(sclk_o);
            if (run > maxrun) maxrun = run;
            if (ref_o) begin
                if (last_ref >= 0 && cyc > 256) begin
                    check(cyc - last_ref == 256, "R9", cyc - last_ref, 256);
                    spacing_checks++;
                end
                last_ref = cyc;
            end
        end
        if (capture && cap_idx < 256) begin
            first_run[cap_idx] = sclk_o;
            cap_idx++;
        end
        if (compare && cap_idx < 256) begin
            check(sclk_o == first_run[cap_idx], "R5", sclk_o, first_run[cap_idx]);
            cap_idx++;
        end
        prev_s  = sclk_o;
        prev_m  = start_o;
        last_en = e;
    endtask

    initial begin
        build_model_pattern();
        // R2: default pattern starts 0,1 and has the expected edge count from the bench model
        last_ref = -1;
        @(negedge clk);
        // R10 reset state
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
        // Phase A: continuous enable, four periods plus margin
        stats_on = 1; capture = 1; cap_idx = 0;
        for (int i = 0; i < 4 * 256 + 4; i++) tick(1'b0, 1'b1);
        stats_on = 0; capture = 0;
        check(spacing_checks >= 2, "R9", spacing_checks, 2);
        // Phase B: gated enable
        for (int i = 0; i < 700; i++) tick(1'b0, ((i % 5) != 2) && ((i % 11) != 0));
        // Phase C: reset mid-run and replay
        for (int i = 0; i < 2; i++) tick(1'b1, 1'b1);
        compare = 1; cap_idx = 0;
        for (int i = 0; i < 300; i++) tick(1'b0, 1'b1);
        compare = 0;
        // Phase D: long stall
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog cycle=%0d actual=%0d expected=%0d", cyc, 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule